// File: doc/BRIEF.md
# Destination Address Receive Filter

This block decides, for every received Ethernet frame, whether the frame is kept or dropped, using only its 6-byte destination address. Software programs the filter by streaming a 192-byte setup frame into a loader. The setup frame is cut into 16 slots of 12 bytes. In each slot only six byte positions carry address data, and the rest is padding. The loader drops every multicast slot and packs the unicast slots, in order, into a table. A count records how many table entries are valid.

Lookups are issued by a one-cycle destination-valid strobe. A frame is kept in three cases: promiscuous mode is on, the destination is a group (multicast) address, or the destination equals a valid table entry. The decision appears on registered outputs one cycle after the strobe. The whole table is compared in parallel, so a new lookup may be issued every cycle. Loading and lookup are mutually exclusive, and a busy output shows that a load is in progress.

Top module: `rx_dest_filter`

## Requirements
- R1: A `load_start` pulse while idle raises `busy` on the next cycle. `busy` stays high until 192 setup bytes have been accepted through `ld_valid`, and it is low in the cycle after the 192nd byte. A `load_start` while `busy` is high is ignored and does not restart the byte count. Idle cycles between bytes are allowed.
- R2: Within each 12-byte slot, address bytes 0..5 come from slot offsets 0, 1, 4, 5, 8 and 9, in that order. Bytes at offsets 2, 3, 6, 7, 10 and 11 have no effect on the table.
- R3: A slot whose address byte 0 has bit 0 set (`dst_addr[40]` in table terms) is skipped. Each unicast slot is stored in the next free table entry, starting at entry 0. `entry_count` reports the number stored, from 0 to 16.
- R4: An accepted `load_start` clears `entry_count` to 0 on the next cycle. This discards the previous table, and the new setup frame replaces it.
- R5: When `promisc_en` is high, every lookup is accepted.
- R6: Every destination with `dst_addr[40]` set is accepted, and `accept_mcast` is 1. A lookup of a destination with `dst_addr[40]` clear returns `accept_mcast` = 0.
- R7: Outside promiscuous mode, a destination with `dst_addr[40]` clear is accepted only when it equals one of the first `entry_count` table entries. Entries at or above the count, including entries left over from an earlier, larger table, never match.
- R8: `dec_valid` is high for exactly the one cycle after each `dst_valid` cycle. `accept` and `accept_mcast` keep their values until the next decision. `dst_valid` is never raised while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| promisc_en | input | 1 | Promiscuous mode: accept every frame |
| load_start | input | 1 | Begin loading a new setup frame |
| ld_valid | input | 1 | Setup byte present on `ld_byte` |
| ld_byte | input | 8 | Setup frame byte stream |
| dst_valid | input | 1 | Lookup strobe |
| dst_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| busy | output | 1 | Setup load in progress |
| entry_count | output | 5 | Number of valid unicast table entries |
| dec_valid | output | 1 | Decision valid, one cycle after `dst_valid` |
| accept | output | 1 | Frame accepted |
| accept_mcast | output | 1 | Accepted destination is a group address |

## Verification
The bench builds setup frames from a computed address list and fills the padding positions with distinct non-zero bytes. A lookup on an address assembled from the padding catches a loader that takes the wrong offsets. If the loader stored multicast slots or left holes in the table, the count would be wrong and some packed entries would not be found. One load is nearly all multicast and is followed by lookups on addresses from the previous full table, which exposes a design that does not mask entries at or above the count. A second load_start in the middle of a load checks that the byte counter is not restarted; a restarting design would hold busy too long and misplace every entry.

// File: rtl/rx_dest_filter_pkg.sv
package rx_dest_filter_pkg;
  localparam int ADDR_W      = 48;
  localparam int BYTE_W      = 8;
  localparam int SLOT_BYTES  = 12;   // stride of one setup slot
  localparam int OFF_W       = 4;    // offset counter inside a slot
  localparam int LAST_ADDR_OFF = 9;  // offset carrying address byte 5
  localparam int PRE_BYTES   = 5;    // address bytes buffered before the last one
  localparam int GROUP_BIT   = ADDR_W - BYTE_W; // LSB of address byte 0
endpackage

// File: rtl/rxf_setup_loader.sv
module rxf_setup_loader
  import rx_dest_filter_pkg::*;
#(
  parameter int SLOTS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_start,
  input  logic              ld_valid,
  input  logic [BYTE_W-1:0] ld_byte,
  output logic              busy,
  output logic              tbl_clear,
  output logic              ent_valid,
  output logic [ADDR_W-1:0] ent_addr
);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOTS - 1);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(SLOT_BYTES - 1);
  localparam logic [OFF_W-1:0] OFF_END  = OFF_W'(LAST_ADDR_OFF);
  localparam int BUF_W = PRE_BYTES * BYTE_W;

  logic                busy_q, busy_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [OFF_W-1:0]    off_q, off_d;
  logic [BUF_W-1:0]    buf_q, buf_d;
  logic                ent_valid_q;
  logic [ADDR_W-1:0]   ent_addr_q;

  logic start_acc, byte_acc, keep_byte, ent_fire;
  logic [2:0] pos;

  assign start_acc = load_start & ~busy_q;
  assign byte_acc  = ld_valid & busy_q;
  // Meaningful offsets are 0,1,4,5,8,9: bit 1 clear, byte index from bits 3:2 and 0
  assign keep_byte = ~off_q[1];
  assign pos       = {off_q[3:2], off_q[0]};
  assign ent_fire  = byte_acc & (off_q == OFF_END);

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    off_d  = off_q;
    buf_d  = buf_q;
    if (start_acc) begin
      busy_d = 1'b1;
      idx_d  = '0;
      off_d  = '0;
    end else if (byte_acc) begin
      if (keep_byte) begin
        for (int k = 0; k < PRE_BYTES; k++) begin
          if (pos == 3'(k)) buf_d[(PRE_BYTES-1-k)*BYTE_W +: BYTE_W] = ld_byte;
        end
      end
      if (off_q == OFF_LAST) begin
        off_d = '0;
        idx_d = idx_q + 1'b1;
        if (idx_q == IDX_LAST) busy_d = 1'b0;
      end else begin
        off_d = off_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      off_q  <= '0;
      buf_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      off_q  <= off_d;
      buf_q  <= buf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid_q <= 1'b0;
      ent_addr_q  <= '0;
    end else begin
      ent_valid_q <= ent_fire;
      if (ent_fire) ent_addr_q <= {buf_q, ld_byte};
    end
  end

  assign busy      = busy_q;
  assign tbl_clear = start_acc;
  assign ent_valid = ent_valid_q;
  assign ent_addr  = ent_addr_q;

  // R1: an idle start always opens a load
  p_start_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_start && !busy_q) |=> busy_q);
  // R1: busy only rises because of a start request
  p_busy_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(load_start));
  // R2: extracted entries are only produced inside a load
  p_entry_in_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid_q |-> busy_q);
endmodule

// File: rtl/rxf_addr_table.sv
module rxf_addr_table
  import rx_dest_filter_pkg::*;
#(
  parameter int SLOTS = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          wr_valid,
  input  logic [ADDR_W-1:0]             wr_addr,
  output logic [SLOTS-1:0][ADDR_W-1:0]  slot_addr,
  output logic [SLOTS-1:0]              slot_live,
  output logic [$clog2(SLOTS+1)-1:0]    count
);
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SLOTS);

  logic [CNT_W-1:0] count_q, count_d;
  logic             wr_en;

  assign wr_en = wr_valid & ~wr_addr[GROUP_BIT] & (count_q < CNT_MAX);

  always_comb begin
    count_d = count_q;
    if (clear)      count_d = '0;
    else if (wr_en) count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [ADDR_W-1:0] mem_q;
    logic              slot_we;
    assign slot_we = wr_en & (count_q == CNT_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q <= '0;
      else if (slot_we) mem_q <= wr_addr;
    end
    assign slot_addr[s] = mem_q;
    assign slot_live[s] = (CNT_W'(s) < count_q);
  end

  assign count = count_q;

  // R3: the count never exceeds the table size
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_MAX);
  // R3: a group-address entry never advances the count
  p_group_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr[GROUP_BIT] && !clear) |=> count_q == $past(count_q));
  // R4: a new load empties the table
  p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count_q == '0);
endmodule

// File: rtl/rxf_match.sv
module rxf_match
  import rx_dest_filter_pkg::*;
#(
  parameter int SLOTS = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dst_valid,
  input  logic [ADDR_W-1:0]             dst_addr,
  input  logic                          promisc,
  input  logic [SLOTS-1:0][ADDR_W-1:0]  slot_addr,
  input  logic [SLOTS-1:0]              slot_live,
  output logic                          dec_valid,
  output logic                          accept,
  output logic                          accept_mcast
);
  logic [SLOTS-1:0] hit;
  logic             is_group, acc_d;
  logic             dec_valid_q, accept_q, mcast_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
    assign hit[s] = slot_live[s] & (slot_addr[s] == dst_addr);
  end

  assign is_group = dst_addr[GROUP_BIT];
  assign acc_d    = promisc | is_group | (|hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_q <= 1'b0;
      accept_q    <= 1'b0;
      mcast_q     <= 1'b0;
    end else begin
      dec_valid_q <= dst_valid;
      if (dst_valid) begin
        accept_q <= acc_d;
        mcast_q  <= is_group;
      end
    end
  end

  assign dec_valid    = dec_valid_q;
  assign accept       = accept_q;
  assign accept_mcast = mcast_q;

  // R5: promiscuous lookups are always accepted
  p_promisc_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && promisc) |=> (dec_valid_q && accept_q));
  // R6: group destinations are accepted and flagged
  p_group_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && dst_addr[GROUP_BIT]) |=> (accept_q && mcast_q));
  // R7: with an empty table a plain unicast lookup is rejected
  p_empty_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !promisc && !dst_addr[GROUP_BIT] && slot_live == '0) |=> !accept_q);
  // R8: one decision per strobe, in the next cycle
  p_decision_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> dec_valid_q);
  p_decision_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_valid |=> !dec_valid_q);
  // R8: results hold between decisions
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_valid |=> ($stable(accept_q) && $stable(mcast_q)));
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rx_dest_filter_pkg::*;
#(
  parameter int SLOTS = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         promisc_en,
  input  logic                         load_start,
  input  logic                         ld_valid,
  input  logic [7:0]                   ld_byte,
  input  logic                         dst_valid,
  input  logic [47:0]                  dst_addr,
  output logic                         busy,
  output logic [$clog2(SLOTS+1)-1:0]   entry_count,
  output logic                         dec_valid,
  output logic                         accept,
  output logic                         accept_mcast
);
  logic                         tbl_clear;
  logic                         ent_valid;
  logic [ADDR_W-1:0]            ent_addr;
  logic [SLOTS-1:0][ADDR_W-1:0] slot_addr;
  logic [SLOTS-1:0]             slot_live;

  rxf_setup_loader #(.SLOTS(SLOTS)) u_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_start (load_start),
    .ld_valid   (ld_valid),
    .ld_byte    (ld_byte),
    .busy       (busy),
    .tbl_clear  (tbl_clear),
    .ent_valid  (ent_valid),
    .ent_addr   (ent_addr)
  );

  rxf_addr_table #(.SLOTS(SLOTS)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (tbl_clear),
    .wr_valid  (ent_valid),
    .wr_addr   (ent_addr),
    .slot_addr (slot_addr),
    .slot_live (slot_live),
    .count     (entry_count)
  );

  rxf_match #(.SLOTS(SLOTS)) u_match (
    .clk          (clk),
    .rst_n        (rst_n),
    .dst_valid    (dst_valid),
    .dst_addr     (dst_addr),
    .promisc      (promisc_en),
    .slot_addr    (slot_addr),
    .slot_live    (slot_live),
    .dec_valid    (dec_valid),
    .accept       (accept),
    .accept_mcast (accept_mcast)
  );

  // R8: lookups and loads never overlap
  p_lookup_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dst_valid && busy));
endmodule

// File: tb/rx_dest_filter_tb_top.sv
`timescale 1ns/1ps
module rx_dest_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        promisc_en, load_start, ld_valid, dst_valid;
  logic [7:0]  ld_byte;
  logic [47:0] dst_addr;
  logic        busy, dec_valid, accept, accept_mcast;
  logic [4:0]  entry_count;

  always #2.5 clk = ~clk;

  rx_dest_filter dut_i (
    .clk(clk), .rst_n(rst_n), .promisc_en(promisc_en), .load_start(load_start),
    .ld_valid(ld_valid), .ld_byte(ld_byte), .dst_valid(dst_valid), .dst_addr(dst_addr),
    .busy(busy), .entry_count(entry_count), .dec_valid(dec_valid),
    .accept(accept), .accept_mcast(accept_mcast)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0]  frm [192];
  logic [47:0] exp_addr [16];
  bit          exp_mc [16];
  int          exp_cnt;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] mk_addr(input int s, input int i, input bit mc);
    logic [47:0] a;
    a = {8'(s*29 + i*6), 8'(i*13 + 5), 32'(s*32'h01000193 ^ (i+1)*32'h7F4A7C15)};
    a[40] = mc;
    return a;
  endfunction

  // Independent reference decision
  function automatic bit ref_accept(input logic [47:0] a, input bit p);
    bit r;
    r = p | a[40];
    for (int i = 0; i < 16; i++) if (!exp_mc[i] && exp_addr[i] == a) r = 1'b1;
    return r;
  endfunction

  function automatic bit pick_mc(input int mode, input int e);
    case (mode)
      0: return (e % 3) == 1;
      1: return !(e == 2 || e == 9 || e == 15);
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic build(input int s, input int mode);
    exp_cnt = 0;
    for (int e = 0; e < 16; e++) begin
      exp_mc[e]   = pick_mc(mode, e);
      exp_addr[e] = mk_addr(s, e, exp_mc[e]);
      if (!exp_mc[e]) exp_cnt++;
      for (int off = 0; off < 12; off++) begin
        if ((off & 2) == 0) begin
          int p;
          p = (off / 4) * 2 + (off % 2);
          frm[e*12 + off] = exp_addr[e][47 - 8*p -: 8];
        end else begin
          frm[e*12 + off] = 8'hA0 ^ 8'(e*12 + off);
        end
      end
    end
  endtask

  // Address made of the padding bytes of slot e (R2)
  function automatic logic [47:0] pad_addr(input int e);
    return {frm[e*12+2], frm[e*12+3], frm[e*12+6], frm[e*12+7], frm[e*12+10], frm[e*12+11]};
  endfunction

  task automatic do_load(input bit restart);
    load_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after start", 64'(busy), 64'd1);
    chk(entry_count == 5'd0, "R4", "count cleared by start", 64'(entry_count), 64'd0);
    for (int b = 0; b < 192; b++) begin
      if (b % 7 == 3) @(negedge clk);
      if (b == 191) chk(busy == 1'b1, "R1", "busy before last byte", 64'(busy), 64'd1);
      ld_valid   = 1'b1;
      ld_byte    = frm[b];
      load_start = restart && (b == 100);
      @(negedge clk);
      ld_valid   = 1'b0;
      load_start = 1'b0;
    end
    chk(busy == 1'b0, "R1", "busy after 192 bytes", 64'(busy), 64'd0);
    chk(entry_count == 5'(exp_cnt), "R3", "unicast count", 64'(entry_count), 64'(exp_cnt));
  endtask

  task automatic lookup(input logic [47:0] a, input bit p, input string req);
    bit ea;
    ea = ref_accept(a, p);
    dst_valid  = 1'b1;
    dst_addr   = a;
    promisc_en = p;
    @(negedge clk);
    dst_valid = 1'b0;
    chk(dec_valid == 1'b1, "R8", "decision valid", 64'(dec_valid), 64'd1);
    chk(accept == ea, req, "accept", 64'(accept), 64'(ea));
    chk(accept_mcast == a[40], "R6", "group flag", 64'(accept_mcast), 64'(a[40]));
    dst_addr = ~a;
    @(negedge clk);
    chk(dec_valid == 1'b0, "R8", "single-cycle valid", 64'(dec_valid), 64'd0);
    chk(accept == ea, "R8", "accept holds", 64'(accept), 64'(ea));
    promisc_en = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int e = 0; e < 16; e++) begin
      lookup(exp_addr[e], 1'b0, req);
      lookup(exp_addr[e] ^ 48'h0000_0001_0000, 1'b0, "R7");
    end
  endtask

  initial begin
    rst_n = 1'b0; promisc_en = 1'b0; load_start = 1'b0; ld_valid = 1'b0;
    ld_byte = '0; dst_valid = 1'b0; dst_addr = '0;
    for (int e = 0; e < 16; e++) begin exp_addr[e] = '0; exp_mc[e] = 1'b1; end
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "reset busy", 64'(busy), 64'd0);
    chk(entry_count == 5'd0, "R3", "reset count", 64'(entry_count), 64'd0);
    chk(dec_valid == 1'b0, "R8", "reset valid", 64'(dec_valid), 64'd0);
    chk(accept == 1'b0, "R8", "reset accept", 64'(accept), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Mixed table: every third slot is a group address
    build(1, 0);
    do_load(1'b0);
    sweep("R3");
    for (int e = 0; e < 16; e++) begin
      logic [47:0] pa;
      pa = pad_addr(e);
      lookup(pa, 1'b0, "R2");
      lookup(pa, 1'b1, "R5");
    end
    lookup(48'h0200_0000_0001, 1'b1, "R5");
    lookup(48'h0300_0000_0001, 1'b1, "R6");
    lookup(48'hFFFF_FFFF_FFFF, 1'b0, "R6");

    // Mostly-group table, with a restart request mid-load that must be ignored
    build(2, 1);
    do_load(1'b1);
    sweep("R4");
    for (int e = 0; e < 16; e++) lookup(mk_addr(1, e, pick_mc(0, e)), 1'b0, "R4");

    // Full unicast table: all 16 slots, including the last
    build(3, 2);
    do_load(1'b0);
    sweep("R3");

    // All-group table: count zero, stale entries must not match
    build(4, 3);
    do_load(1'b0);
    for (int e = 0; e < 16; e++) lookup(mk_addr(3, e, 1'b0), 1'b0, "R7");
    sweep("R6");

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule